// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Controller

This block holds the control and status state of one double-buffered USB IN endpoint in a device controller. It sits between the CPU register interface and the transmit engine. On the CPU side, the block offers a status word plus four write-one strobes: mark a buffer ready, clear underrun, flush, and reset the data toggle. On the engine side, it takes an endpoint-enable level, an IN-token-start pulse and a packet-acknowledged pulse.

A two-bit flag pair shows how many of the two packet buffers hold data. The CPU fills a buffer, then marks it ready. Each acknowledged packet frees a buffer. A flush frees both. For isochronous traffic, the block raises an underrun flag when a token arrives and no packet is waiting. The block also keeps the DATA0/DATA1 sequence bit. It advances the byte write and read pointers of the external FIFO, and resets both pointers when the toggle is reinitialised.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After a synchronous reset, the flag pair reads 11, underrun is 0, the data PID is DATA0 (data_pid = 0), and both FIFO pointers are 0.
- R2: The first enabled cycle after a disabled one sets the flag pair to 00, whatever buffer events arrive in that cycle. While ep_enable is 0, set-ready, flush, packet-sent and IN-token events leave the flag pair and underrun unchanged.
- R3: A set-ready strobe moves the flag pair from 00 to 01, and from 01 to 11. With STS1 (flag bit 1) at 1, a set-ready strobe is ignored.
- R4: A packet-sent pulse moves the flag pair from 11 to 01, and from 01 to 00. At 00 it has no effect on the flag pair.
- R5: When a set-ready strobe is accepted in the same cycle as a packet-sent pulse, the flag pair is unchanged.
- R6: A CPU flush strobe or a hardware auto-flush pulse sets the flag pair to 00. It takes priority over set-ready and packet-sent in the same cycle.
- R7: An IN-token pulse sets underrun only when the endpoint is enabled, ep_iso is 1, and the flag pair is 00 at that edge.
- R8: A clear-underrun strobe clears underrun. If a setting IN token arrives in the same cycle, underrun ends at 1.
- R9: For a non-isochronous endpoint, data_pid inverts on every enabled packet-sent pulse. For an isochronous endpoint, a packet-sent pulse leaves data_pid at DATA0.
- R10: A toggle-init strobe sets data_pid to DATA0 and both FIFO pointers to 0. It overrides a packet-sent pulse or pointer strobes in the same cycle.
- R11: wr_ptr advances by one for each fifo_wr_en cycle, and rd_ptr for each fifo_rd_en cycle. Both wrap modulo 2^PTR_W.
- R12: csr_rdata bit 0 is STS0, bit 1 is STS1, and bit 2 is underrun. Bits 7:3, where the control strobes sit, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_enable | input | 1 | Endpoint enabled level |
| ep_iso | input | 1 | Endpoint uses isochronous transfers |
| cpu_set_rdy | input | 1 | CPU write-one: a buffer has been loaded |
| cpu_clr_urun | input | 1 | CPU write-one: clear underrun |
| cpu_flush | input | 1 | CPU write-one: discard both buffers |
| cpu_tog_init | input | 1 | CPU write-one: force DATA0 and zero the FIFO pointers |
| auto_flush | input | 1 | Hardware flush request |
| tok_in | input | 1 | Start of an IN token for this endpoint |
| tx_ok | input | 1 | Packet sent and acknowledged |
| fifo_wr_en | input | 1 | CPU wrote one FIFO byte |
| fifo_rd_en | input | 1 | Engine read one FIFO byte |
| sts_flags | output | 2 | Buffer occupancy flags {STS1, STS0} |
| underrun | output | 1 | Isochronous underrun flag |
| data_pid | output | 1 | Next data PID: 0 = DATA0, 1 = DATA1 |
| wr_ptr | output | PTR_W | FIFO write pointer |
| rd_ptr | output | PTR_W | FIFO read pointer |
| csr_rdata | output | 8 | Status word seen by the CPU |

## Verification
The bench targets the same-cycle collisions. A load together with a send must cancel out, or the flag pair drifts by one. A flush together with a load must still leave the pair empty, or a stale packet is sent. A clear together with an empty token must leave underrun set, or an underrun is lost. A toggle-init together with an acknowledge must leave DATA0, or the host sees a sequence error.

The bench also drives a load into a full pair, which a design without the STS1 guard would turn into the illegal code 10. It sends a packet from an empty pair, which a design without a floor would wrap to full. It raises enable while a load is pending, where a design that lets the load through would report one packet instead of none. It runs more than 2^PTR_W pointer steps, which catches a pointer that saturates instead of wrapping.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_ONE   = 2'b01,
        OCC_TWO   = 2'b11
    } occ_t;

    typedef struct packed {
        logic active;
        logic rise;
        logic load;
        logic send;
        logic flush;
    } buf_evt_t;

    typedef struct packed {
        logic [4:0] strobes_rd;
        logic       urun;
        logic [1:0] flags;
    } csr_stat_t;

    function automatic occ_t occ_inc(input occ_t cur);
        return (cur == OCC_EMPTY) ? OCC_ONE : OCC_TWO;
    endfunction

    function automatic occ_t occ_dec(input occ_t cur);
        return (cur == OCC_TWO) ? OCC_ONE : OCC_EMPTY;
    endfunction

    function automatic csr_stat_t pack_status(input occ_t occ, input logic urun);
        csr_stat_t s;
        s.strobes_rd = '0;
        s.urun       = urun;
        s.flags      = occ;
        return s;
    endfunction

endpackage

// File: rtl/in_ep_occ.sv
module in_ep_occ
    import usb_in_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  buf_evt_t evt,
    output occ_t     occ
);
    logic load_ok;
    logic send_ok;

    always_comb begin
        load_ok = evt.load && (occ != OCC_TWO);
        send_ok = evt.send && (occ != OCC_EMPTY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= OCC_TWO;
        end else if (evt.rise) begin
            occ <= OCC_EMPTY;
        end else if (evt.active) begin
            if (evt.flush) begin
                occ <= OCC_EMPTY;
            end else if (load_ok && !send_ok) begin
                occ <= occ_inc(occ);
            end else if (send_ok && !load_ok) begin
                occ <= occ_dec(occ);
            end
        end
    end
endmodule

// File: rtl/in_ep_urun.sv
module in_ep_urun
    import usb_in_ep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic iso,
    input  logic tok,
    input  logic clr,
    input  occ_t occ,
    output logic urun
);
    logic starve;

    always_comb starve = active && iso && tok && (occ == OCC_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            urun <= 1'b0;
        end else if (starve) begin
            urun <= 1'b1;
        end else if (clr) begin
            urun <= 1'b0;
        end
    end
endmodule

// File: rtl/in_ep_seq.sv
module in_ep_seq (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic iso,
    input  logic ack,
    input  logic init,
    output logic pid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pid <= 1'b0;
        end else if (init) begin
            pid <= 1'b0;
        end else if (active && ack) begin
            pid <= iso ? 1'b0 : ~pid;
        end
    end
endmodule

// File: rtl/in_ep_ptr.sv
module in_ep_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ep_enable,
    input  logic             ep_iso,
    input  logic             cpu_set_rdy,
    input  logic             cpu_clr_urun,
    input  logic             cpu_flush,
    input  logic             cpu_tog_init,
    input  logic             auto_flush,
    input  logic             tok_in,
    input  logic             tx_ok,
    input  logic             fifo_wr_en,
    input  logic             fifo_rd_en,
    output logic [1:0]       sts_flags,
    output logic             underrun,
    output logic             data_pid,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       csr_rdata
);
    localparam int NPTR = 2;

    logic      en_q;
    buf_evt_t  evt;
    occ_t      occ;
    logic      urun_q;
    csr_stat_t stat;
    logic [NPTR-1:0] ptr_step;
    logic [PTR_W-1:0] ptr_val [NPTR];

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ep_enable;
    end

    always_comb begin
        evt.active = ep_enable;
        evt.rise   = ep_enable && !en_q;
        evt.load   = cpu_set_rdy;
        evt.send   = tx_ok;
        evt.flush  = cpu_flush || auto_flush;
    end

    in_ep_occ u_occ (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .occ (occ)
    );

    in_ep_urun u_urun (
        .clk    (clk),
        .rst    (rst),
        .active (ep_enable),
        .iso    (ep_iso),
        .tok    (tok_in),
        .clr    (cpu_clr_urun),
        .occ    (occ),
        .urun   (urun_q)
    );

    in_ep_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .active (ep_enable),
        .iso    (ep_iso),
        .ack    (tx_ok),
        .init   (cpu_tog_init),
        .pid    (data_pid)
    );

    assign ptr_step = {fifo_rd_en, fifo_wr_en};

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        in_ep_ptr #(.PTR_W(PTR_W)) u_ptr (
            .clk  (clk),
            .rst  (rst),
            .clr  (cpu_tog_init),
            .step (ptr_step[g]),
            .ptr  (ptr_val[g])
        );
    end

    always_comb begin
        stat      = pack_status(occ, urun_q);
        sts_flags = occ;
        underrun  = urun_q;
        wr_ptr    = ptr_val[0];
        rd_ptr    = ptr_val[1];
        csr_rdata = stat;
    end
endmodule

// File: rtl/usb_in_ep_chk.sv
module usb_in_ep_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ep_enable,
    input logic             ep_iso,
    input logic             cpu_set_rdy,
    input logic             cpu_clr_urun,
    input logic             cpu_flush,
    input logic             cpu_tog_init,
    input logic             auto_flush,
    input logic             tok_in,
    input logic             tx_ok,
    input logic             fifo_wr_en,
    input logic [1:0]       sts_flags,
    input logic             underrun,
    input logic             data_pid,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [7:0]       csr_rdata
);
    // R2
    enable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_enable) |=> (sts_flags == 2'b00));

    // R3
    full_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_enable && $past(ep_enable) && sts_flags == 2'b11 && cpu_set_rdy
         && !tx_ok && !cpu_flush && !auto_flush) |=> (sts_flags == 2'b11));

    // R3
    flag_code_chk: assert property (@(posedge clk) disable iff (rst)
        sts_flags != 2'b10);

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_enable && (cpu_flush || auto_flush)) |=> (sts_flags == 2'b00));

    // R7
    starve_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_enable && ep_iso && tok_in && sts_flags == 2'b00) |=> underrun);

    // R8
    clear_urun_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clr_urun && !tok_in) |=> !underrun);

    // R9
    iso_pid_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_enable && ep_iso && tx_ok) |=> !data_pid);

    // R10
    tog_init_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_tog_init |=> (!data_pid && wr_ptr == '0 && rd_ptr == '0));

    // R11
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr_en && !cpu_tog_init) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

    // R12
    csr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[7:3] == 5'b0 && csr_rdata[2] == underrun && csr_rdata[1:0] == sts_flags));
endmodule

bind usb_in_ep_ctrl usb_in_ep_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ep_enable    (ep_enable),
    .ep_iso       (ep_iso),
    .cpu_set_rdy  (cpu_set_rdy),
    .cpu_clr_urun (cpu_clr_urun),
    .cpu_flush    (cpu_flush),
    .cpu_tog_init (cpu_tog_init),
    .auto_flush   (auto_flush),
    .tok_in       (tok_in),
    .tx_ok        (tx_ok),
    .fifo_wr_en   (fifo_wr_en),
    .sts_flags    (sts_flags),
    .underrun     (underrun),
    .data_pid     (data_pid),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .csr_rdata    (csr_rdata)
);

// File: tb/sim_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_in_ep_ctrl;
    localparam int PW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, iso = 0, set = 0, clr = 0, fl = 0, tog = 0, af = 0, tok = 0, ok = 0, wr = 0, rd = 0;
    logic [1:0]    sts_flags;
    logic          underrun, data_pid;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [7:0]    csr_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    usb_in_ep_ctrl #(.PTR_W(PW)) u0 (
        .clk(clk), .rst(rst), .ep_enable(en), .ep_iso(iso),
        .cpu_set_rdy(set), .cpu_clr_urun(clr), .cpu_flush(fl), .cpu_tog_init(tog),
        .auto_flush(af), .tok_in(tok), .tx_ok(ok), .fifo_wr_en(wr), .fifo_rd_en(rd),
        .sts_flags(sts_flags), .underrun(underrun), .data_pid(data_pid),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .csr_rdata(csr_rdata)
    );

    typedef struct {
        logic [1:0]    fl;
        logic          ur;
        logic          pid;
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        string         tag;
    } exp_t;

    exp_t q[$];

    // reference state
    logic [1:0]    m_occ = 2'b11;
    logic          m_ur = 0, m_pid = 0, m_enq = 0;
    logic [PW-1:0] m_wp = '0, m_rp = '0;

    task automatic compare(input exp_t e);
        logic [7:0] ecsr;
        ecsr = {5'b0, e.ur, e.fl};
        checks++;
        if (sts_flags !== e.fl || underrun !== e.ur || data_pid !== e.pid ||
            wr_ptr !== e.wp || rd_ptr !== e.rp || csr_rdata !== ecsr) begin
            errors++;
            $display("FAIL %s: flags=%b ur=%b pid=%b wp=%0d rp=%0d csr=%h expected flags=%b ur=%b pid=%b wp=%0d rp=%0d csr=%h",
                     e.tag, sts_flags, underrun, data_pid, wr_ptr, rd_ptr, csr_rdata,
                     e.fl, e.ur, e.pid, e.wp, e.rp, ecsr);
        end
    endtask

    // monitor: pop at the edge the result is produced, compare half a cycle later
    initial begin
        forever begin
            exp_t e;
            logic have;
            @(posedge clk);
            have = 1'b0;
            if (q.size() > 0) begin
                e = q.pop_front();
                have = 1'b1;
            end
            @(negedge clk);
            if (have) compare(e);
        end
    end

    // driver: inputs are already set; compute the expectation and push it
    task automatic tick(input string tag);
        exp_t e;
        logic rise, flush, lok, sok;
        logic [1:0] old_occ;
        old_occ = m_occ;
        rise  = en && !m_enq;
        flush = fl || af;
        lok   = set && (m_occ != 2'b11);
        sok   = ok && (m_occ != 2'b00);
        if (rise) m_occ = 2'b00;
        else if (en) begin
            if (flush) m_occ = 2'b00;
            else if (lok && !sok) m_occ = (m_occ == 2'b00) ? 2'b01 : 2'b11;
            else if (sok && !lok) m_occ = (m_occ == 2'b11) ? 2'b01 : 2'b00;
        end
        if (en && iso && tok && old_occ == 2'b00) m_ur = 1'b1;
        else if (clr) m_ur = 1'b0;
        if (tog) m_pid = 1'b0;
        else if (en && ok) m_pid = iso ? 1'b0 : !m_pid;
        if (tog) begin
            m_wp = '0;
            m_rp = '0;
        end else begin
            if (wr) m_wp = m_wp + 1'b1;
            if (rd) m_rp = m_rp + 1'b1;
        end
        m_enq = en;
        e.fl = m_occ; e.ur = m_ur; e.pid = m_pid; e.wp = m_wp; e.rp = m_rp; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        set = 0; clr = 0; fl = 0; tog = 0; af = 0; tok = 0; ok = 0; wr = 0; rd = 0;
    endtask

    initial begin : watchdog
        #100000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        checks++;
        if (sts_flags !== 2'b11 || underrun !== 1'b0 || data_pid !== 1'b0 ||
            wr_ptr !== '0 || rd_ptr !== '0) begin
            errors++;
            $display("FAIL R1: flags=%b ur=%b pid=%b wp=%0d rp=%0d expected 11 0 0 0 0",
                     sts_flags, underrun, data_pid, wr_ptr, rd_ptr);
        end

        // R2: disabled, loads are ignored
        set = 1; tick("R2 load while disabled");
        en = 1; set = 1; tick("R2 enable edge clears");
        // R3 fill
        set = 1; tick("R3 load 00->01");
        set = 1; tick("R3 load 01->11");
        set = 1; tick("R3 load at 11 ignored");
        // R4 / R9
        ok = 1; tick("R4 send 11->01, R9 pid flips");
        set = 1; ok = 1; tick("R5 load+send holds");
        ok = 1; tick("R4 send 01->00");
        ok = 1; tick("R4 send at 00 no change");
        // R6
        set = 1; tick("R3 load");
        set = 1; tick("R3 load");
        fl = 1; set = 1; tick("R6 cpu flush over load");
        set = 1; tick("R3 load");
        af = 1; ok = 1; tick("R6 auto flush over send");
        // R7 / R8
        iso = 1;
        tok = 1; tick("R7 iso empty token");
        tick("R12 status word with underrun");
        clr = 1; tick("R8 clear underrun");
        tok = 1; clr = 1; tick("R8 set wins over clear");
        clr = 1; tick("R8 clear");
        set = 1; tick("R3 load");
        tok = 1; tick("R7 token with data no underrun");
        ok = 1; tick("R9 iso send keeps DATA0");
        iso = 0;
        tok = 1; tick("R7 non-iso empty token");
        // R10 / R11
        ok = 1; tick("R9 pid to DATA1");
        wr = 1; tick("R11 write step");
        wr = 1; rd = 1; tick("R11 both step");
        wr = 1; tick("R11 write step");
        tog = 1; ok = 1; wr = 1; tick("R10 toggle init over send");
        for (int i = 0; i < (1 << PW) + 1; i++) begin
            wr = 1; rd = (i < 3);
            tick("R11 pointer wrap");
        end
        // R2 disabled events
        set = 1; tick("R3 load");
        en = 0; iso = 1;
        set = 1; tok = 1; tick("R2 disabled load/token ignored");
        ok = 1; fl = 1; tick("R2 disabled send/flush ignored");
        en = 1; set = 1; tick("R2 re-enable clears");
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule